// File: doc/BRIEF.md
# Point-to-Point FIFO Stream Link

This block is a one-way channel from a single producer to a single consumer. It has no address decode, no arbitration and no acknowledge handshake. Each stored entry holds a data word and, when the build enables it, one flag bit. The flag lets the consumer tell control words from plain data. The producer pushes with a write strobe and must hold off while `full_o` is high. The consumer sees the oldest entry on its outputs whenever `exists_o` is high, and a read strobe moves to the next entry.

Data width and address width are parameters, and the number of entries is two to the power of the address width. A mode parameter picks one of two builds:
- **Same-clock build**: the two pointer views are compared directly. The flags are exact, and a write is visible to the consumer in the cycle after it.
- **Separate-clock build**: each side's gray-coded pointer passes through a two-flop synchronizer into the other clock domain. Both flags then lag the far side and err towards safety: `full_o` can stay high, and `exists_o` can stay low, a little longer than needed.

Top module: `stream_link`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `exists_o` and `full_o` are both 0.
- R2: In the same-clock build, after a write into an empty link, `exists_o` is 1 from the next clock edge on, and it stays 1 while at least one entry is stored.
- R3: Whenever `exists_o` is 1, `rd_data_o` and `rd_ctrl_o` show the oldest stored entry. Entries come out in the order they were written, with data and flag kept together.
- R4: After 2**`ADDR_W` writes with no reads, `full_o` is 1. A single read then clears it, and the stored count never goes above 2**`ADDR_W`.
- R5: A write while `full_o` is 1 is dropped. It stores nothing, and the entries already stored come out unchanged.
- R6: A read while `exists_o` is 0 is dropped. It does not move the read pointer, so the next entry written is the next entry read.
- R7: A read and a write in the same cycle, with the link neither empty nor full, leave the stored count unchanged and keep the order.
- R8: With `CTRL_EN` = 0, no flag bit is stored, `rd_ctrl_o` is always 0, and `wr_ctrl_i` has no effect.
- R9: In the separate-clock build, every word written is read exactly once and in order, with the two clocks unrelated. Each pointer changes by at most one gray-code bit per clock edge of its own domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Producer clock |
| rd_clk_i | input | 1 | Consumer clock; tie to `wr_clk_i` in the same-clock build |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Data word to store |
| wr_ctrl_i | input | 1 | Flag bit stored with the word |
| full_o | output | 1 | No free entry; writes are dropped |
| rd_i | input | 1 | Read strobe; advances to the next entry |
| rd_data_o | output | DATA_W | Data of the oldest entry |
| rd_ctrl_o | output | 1 | Flag of the oldest entry |
| exists_o | output | 1 | At least one entry is stored |

## Verification
The assertions expect that `rst_ni` is held low across at least one edge of each clock. They also expect that, in the same-clock build, both clock ports carry the same clock. Under those conditions, the assertion that the stored count stays bounded is valid. The stimulus samples `full_o` and `exists_o` away from the clock edge and changes strobes only at the falling edge of the matching clock. It also drives strobes on purpose while `full_o` or `exists_o` says the strobe will be dropped, so that the overflow and underflow guards are exercised.

// File: rtl/stream_link_pkg.sv
package stream_link_pkg;
  typedef enum logic {
    LINK_SYNC  = 1'b0,
    LINK_ASYNC = 1'b1
  } link_mode_e;
endpackage

// File: rtl/stream_link_g2b.sv
module stream_link_g2b #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  always_comb begin
    bin_o[W-1] = gray_i[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
  end
endmodule

// File: rtl/stream_link_sync.sv
module stream_link_sync
  import stream_link_pkg::*;
#(
  parameter int unsigned W    = 5,
  parameter link_mode_e  MODE = LINK_SYNC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (MODE == LINK_ASYNC) begin : g_two_flop
    logic [W-1:0] meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= '0;
        sync_q <= '0;
      end else begin
        meta_q <= d_i;
        sync_q <= meta_q;
      end
    end
    assign q_o = sync_q;
  end else begin : g_direct
    logic unused_clk, unused_rst;
    assign unused_clk = clk_i;
    assign unused_rst = rst_ni;
    assign q_o        = d_i;
  end
endmodule

// File: rtl/stream_link_mem.sv
module stream_link_mem #(
  parameter int unsigned WORD_W = 33,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // show-ahead: head entry is always on the read port
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/stream_link_wr.sv
module stream_link_wr #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W:0]   rgray_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic              full_o
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] wbin_q, wbin_n, rbin_s, wgray_q;

  stream_link_g2b #(.W(PW)) u_g2b (
    .gray_i(rgray_i),
    .bin_o (rbin_s)
  );

  assign full_o  = (wbin_q[ADDR_W] != rbin_s[ADDR_W]) &&
                   (wbin_q[ADDR_W-1:0] == rbin_s[ADDR_W-1:0]);
  assign we_o    = wr_i & ~full_o;
  assign wbin_n  = wbin_q + PW'(1);
  assign waddr_o = wbin_q[ADDR_W-1:0];
  assign wgray_o = wgray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> $stable(wgray_q)) else $error("write while full moved pointer"); // R5
  AST_WGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1) else $error("write gray jump"); // R9
endmodule

// File: rtl/stream_link_rd.sv
module stream_link_rd #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W:0]   wgray_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic              exists_o
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] rbin_q, rbin_n, rgray_q;
  logic          rd_fire;

  assign exists_o = (rgray_q != wgray_i);
  assign rd_fire  = rd_i & exists_o;
  assign rbin_n   = rbin_q + PW'(1);
  assign raddr_o  = rbin_q[ADDR_W-1:0];
  assign rgray_o  = rgray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_fire) begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !exists_o) |=> $stable(rgray_q)) else $error("read while empty moved pointer"); // R6
  AST_RGRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1) else $error("read gray jump"); // R9
endmodule

// File: rtl/stream_link.sv
module stream_link
  import stream_link_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter bit          CTRL_EN = 1'b1,
  parameter link_mode_e  MODE    = LINK_SYNC
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_ctrl_i,
  output logic              full_o,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_ctrl_o,
  output logic              exists_o
);
  localparam int unsigned WORD_W = DATA_W + (CTRL_EN ? 1 : 0);
  localparam int unsigned PW     = ADDR_W + 1;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] wword, rword;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rd, rgray_wr;
  logic              we;

  if (CTRL_EN) begin : g_ctrl
    assign wword     = {wr_ctrl_i, wr_data_i};
    assign rd_ctrl_o = rword[DATA_W];
  end else begin : g_no_ctrl
    logic unused_ctrl;
    assign unused_ctrl = wr_ctrl_i;
    assign wword       = wr_data_i;
    assign rd_ctrl_o   = 1'b0;
  end
  assign rd_data_o = rword[DATA_W-1:0];

  stream_link_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i  (wr_clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wword),
    .raddr_i(raddr),
    .rdata_o(rword)
  );

  stream_link_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .rgray_i(rgray_wr),
    .we_o   (we),
    .waddr_o(waddr),
    .wgray_o(wgray),
    .full_o (full_o)
  );

  stream_link_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i   (rd_clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .wgray_i (wgray_rd),
    .raddr_o (raddr),
    .rgray_o (rgray),
    .exists_o(exists_o)
  );

  stream_link_sync #(.W(PW), .MODE(MODE)) u_sync_r2w (
    .clk_i (wr_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_wr)
  );

  stream_link_sync #(.W(PW), .MODE(MODE)) u_sync_w2r (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_rd)
  );

  if (MODE == LINK_SYNC) begin : g_level_chk
    logic [PW-1:0] wbin_c, rbin_c, level;
    stream_link_g2b #(.W(PW)) u_g2b_w (.gray_i(wgray), .bin_o(wbin_c));
    stream_link_g2b #(.W(PW)) u_g2b_r (.gray_i(rgray), .bin_o(rbin_c));
    assign level = wbin_c - rbin_c;

    AST_LEVEL_BOUND: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
      level <= PW'(DEPTH)) else $error("stored count above depth"); // R4
    AST_EXISTS_MATCH: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
      exists_o == (level != '0)) else $error("exists disagrees with count"); // R2
  end
endmodule

// File: tb/stream_link_tb.sv
module stream_link_tb;
  import stream_link_pkg::*;

  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int ADW   = 16;
  localparam int AAW   = 3;
  localparam int NASY  = 300;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic aclk_w = 1'b0;
  always #3 aclk_w = ~aclk_w;
  logic aclk_r = 1'b0;
  always #5.5 aclk_r = ~aclk_r;

  logic rst_n;
  logic wr, rd, wctrl, full, exists, rctrl;
  logic [DW-1:0] wdata, rdata;

  logic a_wr, a_rd, a_wctrl, a_full, a_exists, a_rctrl;
  logic [ADW-1:0] a_wdata, a_rdata;

  stream_link #(.DATA_W(DW), .ADDR_W(AW), .CTRL_EN(1'b1), .MODE(LINK_SYNC)) u_dut (
    .wr_clk_i(clk), .rd_clk_i(clk), .rst_ni(rst_n),
    .wr_i(wr), .wr_data_i(wdata), .wr_ctrl_i(wctrl), .full_o(full),
    .rd_i(rd), .rd_data_o(rdata), .rd_ctrl_o(rctrl), .exists_o(exists)
  );

  stream_link #(.DATA_W(ADW), .ADDR_W(AAW), .CTRL_EN(1'b0), .MODE(LINK_ASYNC)) u_dut_async (
    .wr_clk_i(aclk_w), .rd_clk_i(aclk_r), .rst_ni(rst_n),
    .wr_i(a_wr), .wr_data_i(a_wdata), .wr_ctrl_i(a_wctrl), .full_o(a_full),
    .rd_i(a_rd), .rd_data_o(a_rdata), .rd_ctrl_o(a_rctrl), .exists_o(a_exists)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [DW:0] q[$];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of the same-clock link: check outputs, drive, update model
  task automatic step(bit w, logic [DW-1:0] d, bit c, bit r, string req);
    bit full_pre, empty_pre;
    @(negedge clk);
    chk(req, "exists", 64'(exists), 64'(q.size() > 0));
    chk(req, "full", 64'(full), 64'(q.size() == DEPTH));
    if (q.size() > 0) chk(req, "head", 64'({rctrl, rdata}), 64'(q[0]));
    full_pre  = (q.size() == DEPTH);
    empty_pre = (q.size() == 0);
    wr = w; wdata = d; wctrl = c; rd = r;
    @(posedge clk);
    if (r && !empty_pre) void'(q.pop_front());
    if (w && !full_pre) q.push_back({c, d});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    wr = 0; rd = 0; wctrl = 0; wdata = '0;
    a_wr = 0; a_rd = 0; a_wctrl = 1'b1; a_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "exists in reset", 64'(exists), 64'(0));
    chk("R1", "full in reset", 64'(full), 64'(0));
    chk("R1", "async exists in reset", 64'(a_exists), 64'(0));
    chk("R1", "async full in reset", 64'(a_full), 64'(0));
    repeat (3) @(posedge aclk_r);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "exists after reset", 64'(exists), 64'(0));
    chk("R1", "full after reset", 64'(full), 64'(0));

    // R6: reads on an empty link are dropped
    for (int i = 0; i < 3; i++) step(0, '0, 0, 1, "R6");
    step(1, 32'hA5A5_0001, 1, 0, "R2");
    step(0, '0, 0, 0, "R2");
    step(0, '0, 0, 1, "R6");
    step(0, '0, 0, 1, "R6");

    // R4 fill, R5 writes while full
    for (int i = 0; i < DEPTH; i++) step(1, 32'h1000 + i, i[0], 0, "R4");
    for (int i = 0; i < 3; i++) step(1, 32'hDEAD_BEEF, 1, 0, "R5");
    step(1, 32'hBAD0_0000, 0, 1, "R5");
    step(0, '0, 0, 0, "R4");
    for (int i = 0; i < DEPTH + 1; i++) step(0, '0, 0, 1, "R5");

    // R7 simultaneous read and write with a partial fill
    for (int i = 0; i < 4; i++) step(1, 32'h7700 + i, 1, 0, "R7");
    for (int i = 0; i < 20; i++) step(1, 32'h7800 + i, ~i[0], 1, "R7");
    for (int i = 0; i < 6; i++) step(0, '0, 0, 1, "R7");

    // R3 random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, $urandom, $urandom % 2, ($urandom % 3) == 0 || i > 2900, "R3");
    end
    step(0, '0, 0, 0, "R3");

    // R8 and R9 on the separate-clock link
    fork
      begin
        int n = 0;
        while (n < NASY) begin
          @(negedge aclk_w);
          if (!a_full && ($urandom % 4 != 0)) begin
            a_wr = 1'b1; a_wdata = ADW'(n); n++;
          end else a_wr = 1'b0;
        end
        @(negedge aclk_w);
        a_wr = 1'b0;
      end
      begin
        int m = 0;
        while (m < NASY) begin
          @(negedge aclk_r);
          if (a_exists && ($urandom % 3 != 0)) begin
            chk("R9", "async order", 64'(a_rdata), 64'(ADW'(m)));
            chk("R8", "ctrl disabled", 64'(a_rctrl), 64'(0));
            a_rd = 1'b1; m++;
          end else a_rd = 1'b0;
        end
        @(negedge aclk_r);
        a_rd = 1'b0;
      end
    join
    repeat (6) @(negedge aclk_r);
    chk("R9", "async drained", 64'(a_exists), 64'(0));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule